// File: doc/BRIEF.md
# Scanline Sprite Selector and Pixel Resolver

This block builds the sprite layer of one display line at a time. A host writes up to 128 sprite descriptors into an internal attribute table. When a line is started, the block walks the table in ascending index order and keeps the first sprites whose vertical extent covers that line. Any sprites beyond the per-line sprite budget are dropped and flagged. It then breaks each kept sprite into 8-pixel-wide tile slices and fetches the pixel row of each slice through a request/acknowledge port. Vertical flip is applied when the row is chosen and horizontal flip when the slice is stored. Slices beyond the per-line slice budget are dropped and flagged.

Once fetching ends, the block streams the line out one pixel per clock, from the left edge to the right edge. For each pixel it reports the 4-bit colour, the 3-bit palette and the 2-bit priority plane of the winning sprite. A colour of zero is see-through. Among opaque candidates, the sprite with the smaller table index always wins, whatever its priority plane. The priority plane is passed on for a later compositing stage to use. Palette lookup and background mixing are left to other blocks.

Top module: `spr_line_eval`

## Requirements
- R1: A write with `host_we` high stores `host_wdata` at entry `host_addr`. The word layout is: x position [8:0], y position [16:9], tile base [24:17], palette [27:25], priority plane [29:28], horizontal flip [30], vertical flip [31], size code [33:32].
- R2: Size codes 0, 1, 2 and 3 give square sprites of 8, 16, 32 and 64 pixels. A sprite lies on line L when (L − y) mod 256 is less than its size, so a sprite can wrap from the bottom of the range to the top.
- R3: Entries are examined in ascending index order and at most MAX_SPR of them are kept. If a further entry covers the line, it is dropped and `spr_over` is set.
- R4: A kept sprite of size S gives S/8 slices. Slices are fetched sprite by sprite in kept order, and left to right within each sprite. At most MAX_SLICE slices are fetched. If slices remain once the budget is full, they are dropped and `tile_over` is set.
- R5: Let r = L − y, or S − 1 − (L − y) when vertical flip is set. Let c be the slice column, or S/8 − 1 − c when horizontal flip is set. A slice requests tile (base + 16·(r div 8) + c) mod 256 and row r mod 8. `fetch_req` and its fields hold until `fetch_ack`, and nibble k of `fetch_data` is pixel k from the left.
- R6: With horizontal flip set, the pixel order inside every slice of the sprite is reversed. Slice c starts at x + 8c. Pixels at x of LINE_W or more are not shown.
- R7: Colour 0 is transparent. A pixel with no opaque sprite is output with colour, palette and priority all zero.
- R8: Where opaque pixels overlap, the lower-numbered sprite wins even when the other sprite has a higher priority plane. The winner's palette and priority plane are output with its colour.
- R9: After fetching, exactly LINE_W pixels are output on consecutive cycles with `pix_x` rising from 0. `line_done` pulses together with the last pixel. Both flags then hold until the next line start.
- R10: While reset is active and right after it, `pix_valid`, `fetch_req`, `line_done`, `spr_over` and `tile_over` are 0.
- R11: A `line_start` that arrives while a line is being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Attribute write strobe |
| host_addr | input | 7 | Attribute entry index |
| host_wdata | input | 34 | Attribute word (layout in R1) |
| line_start | input | 1 | Start processing a line |
| line_num | input | 8 | Line number, sampled with `line_start` |
| fetch_req | output | 1 | Slice pixel row request |
| fetch_tile | output | 8 | Requested tile number |
| fetch_row | output | 3 | Requested row in the tile |
| fetch_ack | input | 1 | Request served; `fetch_data` is valid |
| fetch_data | input | 32 | Eight 4-bit pixels, nibble k is pixel k |
| pix_valid | output | 1 | Pixel output valid |
| pix_x | output | 8 | Pixel position on the line |
| pix_color | output | 4 | Winning colour index (0 = none) |
| pix_pal | output | 3 | Winning palette |
| pix_prio | output | 2 | Winning priority plane |
| line_done | output | 1 | Pulse with the last pixel of a line |
| spr_over | output | 1 | More sprites covered the line than the budget allows |
| tile_over | output | 1 | More slices were needed than the budget allows |

## Verification
The bench builds the block with its default values: 128 entries, a budget of 32 sprites and 34 slices, and a 256-pixel line. This lets one line hold 40 small sprites, which overruns the sprite budget without touching the slice budget. It also lets five 64-pixel sprites ask for 40 slices, which overruns the slice budget alone. All four sizes, both flips, bottom-to-top wrap, off-screen slices and index-over-priority overlap are then compared against a bench-side model of the whole line.

// File: rtl/spr_line_pkg.sv
package spr_line_pkg;

  localparam int ATTR_W = 34;

  // Sprite descriptor, MSB first.
  typedef struct packed {
    logic [1:0] size;
    logic       vflip;
    logic       hflip;
    logic [1:0] prio;
    logic [2:0] pal;
    logic [7:0] tile;
    logic [7:0] ypos;
    logic [8:0] xpos;
  } spr_attr_t;

  // Edge length in pixels for a size code.
  function automatic logic [6:0] size_px(input logic [1:0] code);
    return 7'd8 << code;
  endfunction

endpackage

// File: rtl/spr_rst_sync.sv
module spr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/spr_attr_ram.sv
module spr_attr_ram
  import spr_line_pkg::*;
#(
  parameter int NUM_SPR = 128,
  parameter int IDX_W   = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [ATTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_addr,
  output spr_attr_t         rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_addr,
  output spr_attr_t         rd_b_data
);
  spr_attr_t mem [NUM_SPR];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= spr_attr_t'(wr_data);
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/spr_scan.sv
module spr_scan
  import spr_line_pkg::*;
#(
  parameter int NUM_SPR = 128,
  parameter int MAX_SPR = 32,
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [7:0]                      line_in,
  output logic [IDX_W-1:0]                rd_addr,
  input  logic [7:0]                      rd_ypos,
  input  logic [1:0]                      rd_size,
  output logic                            busy,
  output logic                            done,
  output logic [7:0]                      line_out,
  output logic [MAX_SPR-1:0][IDX_W-1:0]   list,
  output logic [CNT_W-1:0]                list_cnt,
  output logic                            over
);
  localparam int SEL_W = $clog2(MAX_SPR);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             over_q, over_d;
  logic [7:0]       line_q, line_d;
  logic [7:0]       dy;
  logic             hit, last, push;
  logic [MAX_SPR-1:0][IDX_W-1:0] list_q;

  always_comb begin
    dy   = line_q - rd_ypos;
    hit  = dy < {1'b0, size_px(rd_size)};
    last = idx_q == IDX_W'(NUM_SPR - 1);
    busy_d = busy_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    over_d = over_q;
    line_d = line_q;
    push   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      cnt_d  = '0;
      over_d = 1'b0;
      line_d = line_in;
    end else if (busy_q) begin
      if (hit) begin
        if (cnt_q < CNT_W'(MAX_SPR)) begin
          push  = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end else begin
          over_d = 1'b1;
        end
      end
      idx_d = idx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      over_q <= 1'b0;
      line_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      over_q <= over_d;
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      list_q[cnt_q[SEL_W-1:0]] <= idx_q;
    end
  end

  assign rd_addr  = idx_q;
  assign busy     = busy_q;
  assign done     = busy_q && last;
  assign line_out = line_q;
  assign list     = list_q;
  assign list_cnt = cnt_q;
  assign over     = over_q;
endmodule

// File: rtl/spr_slicer.sv
module spr_slicer
  import spr_line_pkg::*;
#(
  parameter int MAX_SPR   = 32,
  parameter int MAX_SLICE = 34,
  parameter int IDX_W     = 7,
  parameter int LCNT_W    = 6,
  parameter int SCNT_W    = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [7:0]                       line_in,
  input  logic [MAX_SPR-1:0][IDX_W-1:0]    list,
  input  logic [LCNT_W-1:0]                list_cnt,
  output logic [IDX_W-1:0]                 rd_addr,
  input  spr_attr_t                        rd_attr,
  output logic                             fetch_req,
  output logic [7:0]                       fetch_tile,
  output logic [2:0]                       fetch_row,
  input  logic                             fetch_ack,
  input  logic [31:0]                      fetch_data,
  output logic                             busy,
  output logic                             done,
  output logic                             over,
  output logic [SCNT_W-1:0]                slc_cnt,
  output logic [MAX_SLICE-1:0][9:0]        slc_x,
  output logic [MAX_SLICE-1:0][31:0]       slc_pix,
  output logic [MAX_SLICE-1:0][2:0]        slc_pal,
  output logic [MAX_SLICE-1:0][1:0]        slc_prio
);
  localparam int LSEL_W = $clog2(MAX_SPR);
  localparam int SSEL_W = $clog2(MAX_SLICE);

  logic              busy_q, busy_d;
  logic [LCNT_W-1:0] slot_q, slot_d;
  logic [2:0]        col_q, col_d;
  logic [SCNT_W-1:0] cnt_q, cnt_d;
  logic              over_q, over_d;

  logic       slot_ok, room, take, fin;
  logic [6:0] spx;
  logic [3:0] cols;
  logic [7:0] dy, r;
  logic [2:0] tcol;
  logic [31:0] pix_st;
  logic [9:0]  x_st;

  logic [MAX_SLICE-1:0][9:0]  x_q;
  logic [MAX_SLICE-1:0][31:0] pix_q;
  logic [MAX_SLICE-1:0][2:0]  pal_q;
  logic [MAX_SLICE-1:0][1:0]  prio_q;

  always_comb begin
    rd_addr = list[slot_q[LSEL_W-1:0]];
    slot_ok = slot_q < list_cnt;
    room    = cnt_q < SCNT_W'(MAX_SLICE);
    spx     = size_px(rd_attr.size);
    cols    = spx[6:3];
    dy      = line_in - rd_attr.ypos;
    r       = rd_attr.vflip ? (8'(spx) - 8'd1 - dy) : dy;
    tcol    = rd_attr.hflip ? 3'(cols - 4'd1 - {1'b0, col_q}) : col_q;
    fetch_tile = rd_attr.tile + {1'b0, r[5:3], 4'b0000} + {5'b00000, tcol};
    fetch_row  = r[2:0];
    fetch_req  = busy_q && slot_ok && room;
    take       = fetch_req && fetch_ack;
    fin        = busy_q && (!slot_ok || !room);
    x_st       = {1'b0, rd_attr.xpos} + {4'b0000, col_q, 3'b000};
    for (int k = 0; k < 8; k++) begin
      pix_st[4*k +: 4] = rd_attr.hflip ? fetch_data[4*(7-k) +: 4] : fetch_data[4*k +: 4];
    end
  end

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    col_d  = col_q;
    cnt_d  = cnt_q;
    over_d = over_q;
    if (start) begin
      busy_d = 1'b1;
      slot_d = '0;
      col_d  = '0;
      cnt_d  = '0;
      over_d = 1'b0;
    end else if (fin) begin
      busy_d = 1'b0;
      over_d = slot_ok && !room;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (({1'b0, col_q} + 4'd1) == cols) begin
        col_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      col_q  <= col_d;
      cnt_q  <= cnt_d;
      over_q <= over_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      x_q[cnt_q[SSEL_W-1:0]]    <= x_st;
      pix_q[cnt_q[SSEL_W-1:0]]  <= pix_st;
      pal_q[cnt_q[SSEL_W-1:0]]  <= rd_attr.pal;
      prio_q[cnt_q[SSEL_W-1:0]] <= rd_attr.prio;
    end
  end

  assign busy     = busy_q;
  assign done     = fin;
  assign over     = over_q;
  assign slc_cnt  = cnt_q;
  assign slc_x    = x_q;
  assign slc_pix  = pix_q;
  assign slc_pal  = pal_q;
  assign slc_prio = prio_q;
endmodule

// File: rtl/spr_pixmux.sv
module spr_pixmux #(
  parameter int MAX_SLICE = 34,
  parameter int SCNT_W    = 6,
  parameter int LINE_W    = 256,
  parameter int PX_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [SCNT_W-1:0]           slc_cnt,
  input  logic [MAX_SLICE-1:0][9:0]   slc_x,
  input  logic [MAX_SLICE-1:0][31:0]  slc_pix,
  input  logic [MAX_SLICE-1:0][2:0]   slc_pal,
  input  logic [MAX_SLICE-1:0][1:0]   slc_prio,
  output logic                        busy,
  output logic                        pix_valid,
  output logic [PX_W-1:0]             pix_x,
  output logic [3:0]                  pix_color,
  output logic [2:0]                  pix_pal,
  output logic [1:0]                  pix_prio,
  output logic                        line_done
);
  logic            busy_q, busy_d;
  logic [PX_W-1:0] px_q, px_d;
  logic            last;
  logic [9:0]      px_ext, off;
  logic [3:0]      cand, w_col;
  logic [2:0]      w_pal;
  logic [1:0]      w_prio;

  logic            pv_q;
  logic [PX_W-1:0] px_out_q;
  logic [3:0]      col_q;
  logic [2:0]      pal_q;
  logic [1:0]      prio_q;
  logic            done_q;

  // Lowest slice index is visited last, so it overrides the rest.
  always_comb begin
    px_ext = 10'(px_q);
    w_col  = '0;
    w_pal  = '0;
    w_prio = '0;
    off    = '0;
    cand   = '0;
    for (int i = MAX_SLICE - 1; i >= 0; i--) begin
      off  = px_ext - slc_x[i];
      cand = slc_pix[i][{off[2:0], 2'b00} +: 4];
      if ((SCNT_W'(i) < slc_cnt) && (off < 10'd8) && (cand != 4'd0)) begin
        w_col  = cand;
        w_pal  = slc_pal[i];
        w_prio = slc_prio[i];
      end
    end
  end

  always_comb begin
    last   = px_q == PX_W'(LINE_W - 1);
    busy_d = busy_q;
    px_d   = px_q;
    if (start) begin
      busy_d = 1'b1;
      px_d   = '0;
    end else if (busy_q) begin
      px_d = px_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      px_q     <= '0;
      pv_q     <= 1'b0;
      px_out_q <= '0;
      col_q    <= '0;
      pal_q    <= '0;
      prio_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      px_q     <= px_d;
      pv_q     <= busy_q;
      px_out_q <= px_q;
      col_q    <= busy_q ? w_col  : 4'd0;
      pal_q    <= busy_q ? w_pal  : 3'd0;
      prio_q   <= busy_q ? w_prio : 2'd0;
      done_q   <= busy_q && last;
    end
  end

  assign busy      = busy_q;
  assign pix_valid = pv_q;
  assign pix_x     = px_out_q;
  assign pix_color = col_q;
  assign pix_pal   = pal_q;
  assign pix_prio  = prio_q;
  assign line_done = done_q;
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
  import spr_line_pkg::*;
#(
  parameter int NUM_SPR   = 128,
  parameter int MAX_SPR   = 32,
  parameter int MAX_SLICE = 34,
  parameter int LINE_W    = 256,
  localparam int IDX_W    = $clog2(NUM_SPR),
  localparam int PX_W     = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [ATTR_W-1:0] host_wdata,
  input  logic              line_start,
  input  logic [7:0]        line_num,
  output logic              fetch_req,
  output logic [7:0]        fetch_tile,
  output logic [2:0]        fetch_row,
  input  logic              fetch_ack,
  input  logic [31:0]       fetch_data,
  output logic              pix_valid,
  output logic [PX_W-1:0]   pix_x,
  output logic [3:0]        pix_color,
  output logic [2:0]        pix_pal,
  output logic [1:0]        pix_prio,
  output logic              line_done,
  output logic              spr_over,
  output logic              tile_over
);
  localparam int LCNT_W = $clog2(MAX_SPR + 1);
  localparam int SCNT_W = $clog2(MAX_SLICE + 1);

  logic rst_n_i;

  logic [IDX_W-1:0] scan_addr, slc_addr;
  spr_attr_t        scan_attr, slc_attr;

  logic                          scan_busy, scan_done;
  logic [7:0]                    scan_line;
  logic [MAX_SPR-1:0][IDX_W-1:0] list;
  logic [LCNT_W-1:0]             list_cnt;

  logic                         slc_busy, slc_done;
  logic [SCNT_W-1:0]            slc_cnt;
  logic [MAX_SLICE-1:0][9:0]    slc_x;
  logic [MAX_SLICE-1:0][31:0]   slc_pix;
  logic [MAX_SLICE-1:0][2:0]    slc_pal;
  logic [MAX_SLICE-1:0][1:0]    slc_prio;

  logic mux_busy, idle, start_ok;

  assign idle     = !scan_busy && !slc_busy && !mux_busy;
  assign start_ok = line_start && idle;

  spr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  spr_attr_ram #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_ram (
    .clk       (clk),
    .wr_en     (host_we),
    .wr_addr   (host_addr),
    .wr_data   (host_wdata),
    .rd_a_addr (scan_addr),
    .rd_a_data (scan_attr),
    .rd_b_addr (slc_addr),
    .rd_b_data (slc_attr)
  );

  spr_scan #(.NUM_SPR(NUM_SPR), .MAX_SPR(MAX_SPR), .IDX_W(IDX_W), .CNT_W(LCNT_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start_ok),
    .line_in  (line_num),
    .rd_addr  (scan_addr),
    .rd_ypos  (scan_attr.ypos),
    .rd_size  (scan_attr.size),
    .busy     (scan_busy),
    .done     (scan_done),
    .line_out (scan_line),
    .list     (list),
    .list_cnt (list_cnt),
    .over     (spr_over)
  );

  spr_slicer #(.MAX_SPR(MAX_SPR), .MAX_SLICE(MAX_SLICE), .IDX_W(IDX_W),
               .LCNT_W(LCNT_W), .SCNT_W(SCNT_W)) u_slicer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (scan_done),
    .line_in    (scan_line),
    .list       (list),
    .list_cnt   (list_cnt),
    .rd_addr    (slc_addr),
    .rd_attr    (slc_attr),
    .fetch_req  (fetch_req),
    .fetch_tile (fetch_tile),
    .fetch_row  (fetch_row),
    .fetch_ack  (fetch_ack),
    .fetch_data (fetch_data),
    .busy       (slc_busy),
    .done       (slc_done),
    .over       (tile_over),
    .slc_cnt    (slc_cnt),
    .slc_x      (slc_x),
    .slc_pix    (slc_pix),
    .slc_pal    (slc_pal),
    .slc_prio   (slc_prio)
  );

  spr_pixmux #(.MAX_SLICE(MAX_SLICE), .SCNT_W(SCNT_W), .LINE_W(LINE_W), .PX_W(PX_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (slc_done),
    .slc_cnt   (slc_cnt),
    .slc_x     (slc_x),
    .slc_pix   (slc_pix),
    .slc_pal   (slc_pal),
    .slc_prio  (slc_prio),
    .busy      (mux_busy),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_color (pix_color),
    .pix_pal   (pix_pal),
    .pix_prio  (pix_prio),
    .line_done (line_done)
  );
endmodule

// File: rtl/spr_line_chk.sv
module spr_line_chk #(
  parameter int MAX_SLICE = 34,
  parameter int PX_W      = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_start,
  input logic            fetch_req,
  input logic [7:0]      fetch_tile,
  input logic [2:0]      fetch_row,
  input logic            fetch_ack,
  input logic            pix_valid,
  input logic [PX_W-1:0] pix_x,
  input logic [3:0]      pix_color,
  input logic [2:0]      pix_pal,
  input logic [1:0]      pix_prio,
  input logic            line_done,
  input logic            spr_over,
  input logic            tile_over
);
  logic [31:0] fetch_cnt;
  logic        held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_cnt <= '0;
      held      <= 1'b0;
    end else begin
      if (line_done) begin
        fetch_cnt <= '0;
      end else if (fetch_req && fetch_ack) begin
        fetch_cnt <= fetch_cnt + 1'b1;
      end
      if (line_start) begin
        held <= 1'b0;
      end else if (line_done) begin
        held <= 1'b1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_tile) && $stable(fetch_row)); // R5

  AST_SLICE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_cnt < 32'(MAX_SLICE)); // R4

  AST_EMPTY_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_color == 4'd0 |-> pix_pal == 3'd0 && pix_prio == 2'd0); // R7

  AST_PIX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && $past(pix_valid) |-> pix_x == PX_W'($past(pix_x) + 1'b1)); // R9

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> pix_valid && pix_x == {PX_W{1'b1}}); // R9

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    held && !line_start |=> $stable(spr_over) && $stable(tile_over)); // R9

  AST_NO_FETCH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !fetch_req); // R11
endmodule

bind spr_line_eval spr_line_chk #(.MAX_SLICE(MAX_SLICE), .PX_W(PX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .fetch_req  (fetch_req),
  .fetch_tile (fetch_tile),
  .fetch_row  (fetch_row),
  .fetch_ack  (fetch_ack),
  .pix_valid  (pix_valid),
  .pix_x      (pix_x),
  .pix_color  (pix_color),
  .pix_pal    (pix_pal),
  .pix_prio   (pix_prio),
  .line_done  (line_done),
  .spr_over   (spr_over),
  .tile_over  (tile_over)
);

// File: tb/sim_spr_line_eval.sv
module sim_spr_line_eval;
  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic [6:0]  host_addr;
  logic [33:0] host_wdata;
  logic        line_start;
  logic [7:0]  line_num;
  logic        fetch_req;
  logic [7:0]  fetch_tile;
  logic [2:0]  fetch_row;
  logic        fetch_ack;
  logic [31:0] fetch_data;
  logic        pix_valid;
  logic [7:0]  pix_x;
  logic [3:0]  pix_color;
  logic [2:0]  pix_pal;
  logic [1:0]  pix_prio;
  logic        line_done;
  logic        spr_over;
  logic        tile_over;

  int n_chk = 0;
  int n_bad = 0;
  int n_fetch = 0;

  // bench copy of the table
  int ax[128], ay[128], at[128], ap[128], apr[128], ah[128], av[128], az[128];
  // model results
  int e_pix[256];
  int e_so, e_to, e_ns;
  int got[256];

  spr_line_eval u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .line_start(line_start), .line_num(line_num),
    .fetch_req(fetch_req), .fetch_tile(fetch_tile), .fetch_row(fetch_row),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_color(pix_color), .pix_pal(pix_pal), .pix_prio(pix_prio),
    .line_done(line_done), .spr_over(spr_over), .tile_over(tile_over)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] tdata(input int tile, input int row);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) d[4*k +: 4] = 4'((tile * 3 + row * 5 + k * 7 + 1) & 15);
    return d;
  endfunction

  // fetch responder
  initial begin
    fetch_ack  = 1'b0;
    fetch_data = '0;
    forever begin
      @(negedge clk);
      if (fetch_ack) begin
        fetch_ack = 1'b0;
      end else if (fetch_req) begin
        fetch_data = tdata(int'(fetch_tile), int'(fetch_row));
        fetch_ack  = 1'b1;
        n_fetch++;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input int x, input int y, input int tile, input int pal,
                    input int prio, input int hf, input int vf, input int sz);
    ax[i] = x; ay[i] = y; at[i] = tile; ap[i] = pal; apr[i] = prio; ah[i] = hf; av[i] = vf; az[i] = sz;
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = 7'(i);
    host_wdata = {2'(sz), 1'(vf), 1'(hf), 2'(prio), 3'(pal), 8'(tile), 8'(y), 9'(x)};
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 128; i++) wr(i, 0, 200, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic model(input int line);
    int lst[32];
    int n;
    bit stop;
    bit set[256];
    n = 0; e_so = 0; e_to = 0; e_ns = 0; stop = 0;
    for (int p = 0; p < 256; p++) begin e_pix[p] = 0; set[p] = 0; end
    for (int i = 0; i < 128; i++) begin
      if (((line - ay[i]) & 255) < (8 << az[i])) begin
        if (n < 32) begin lst[n] = i; n++; end
        else e_so = 1;
      end
    end
    for (int s = 0; s < n && !stop; s++) begin
      int i, sz, cols, dy, r;
      i = lst[s]; sz = 8 << az[i]; cols = sz / 8;
      dy = (line - ay[i]) & 255;
      r = av[i] ? sz - 1 - dy : dy;
      for (int c = 0; c < cols && !stop; c++) begin
        if (e_ns == 34) begin
          e_to = 1; stop = 1;
        end else begin
          int tc, t;
          logic [31:0] d;
          tc = ah[i] ? cols - 1 - c : c;
          t = (at[i] + 16 * (r >> 3) + tc) & 255;
          d = tdata(t, r & 7);
          e_ns++;
          for (int k = 0; k < 8; k++) begin
            int cv, xp;
            cv = ah[i] ? int'(d[4*(7-k) +: 4]) : int'(d[4*k +: 4]);
            xp = ax[i] + 8 * c + k;
            if (xp < 256 && cv != 0 && !set[xp]) begin
              e_pix[xp] = (apr[i] << 7) | (ap[i] << 4) | cv;
              set[xp] = 1;
            end
          end
        end
      end
    end
  endtask

  task automatic run_line(input int line, input string tag, input int dup);
    int npix, cyc, bad, first;
    bit fin;
    model(line);
    n_fetch = 0; npix = 0; cyc = 0; fin = 0; bad = 0; first = -1;
    for (int p = 0; p < 256; p++) got[p] = -1;
    @(negedge clk);
    line_start = 1'b1;
    line_num   = 8'(line);
    @(negedge clk);
    line_start = 1'b0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      line_start = 1'b0;
      if (dup >= 0 && cyc == 40) begin
        line_start = 1'b1;
        line_num   = 8'(dup);
      end
      if (pix_valid) begin
        got[pix_x] = (int'(pix_prio) << 7) | (int'(pix_pal) << 4) | int'(pix_color);
        npix++;
      end
      if (line_done) fin = 1;
    end
    for (int p = 0; p < 256; p++) begin
      if (got[p] != e_pix[p]) begin
        bad++;
        if (first < 0) first = p;
      end
    end
    check(bad == 0, {tag, " pixel at first mismatch"},
          first < 0 ? 0 : got[first], first < 0 ? 0 : e_pix[first]);
    check(npix == 256, "R9 pixel count", npix, 256);
    check(n_fetch == e_ns, "R4 fetch count", n_fetch, e_ns);
    check(spr_over == 1'(e_so), "R3 spr_over", int'(spr_over), e_so);
    check(tile_over == 1'(e_to), "R4 tile_over", int'(tile_over), e_to);
    if (dup >= 0) begin
      int extra;
      extra = 0;
      repeat (300) begin
        @(negedge clk);
        if (pix_valid || line_done || fetch_req) extra++;
      end
      check(extra == 0, "R11 activity after ignored start", extra, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    line_start = 1'b0; line_num = '0;
    repeat (3) @(negedge clk);
    check({pix_valid, fetch_req, line_done, spr_over, tile_over} == 5'b0,
          "R10 outputs in reset", int'({pix_valid, fetch_req, line_done, spr_over, tile_over}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({pix_valid, fetch_req, line_done, spr_over, tile_over} == 5'b0,
          "R10 outputs after reset", int'({pix_valid, fetch_req, line_done, spr_over, tile_over}), 0);
  endtask

  task automatic t_single();
    clear_all();
    wr(0, 20, 10, 4, 2, 1, 0, 0, 0);
    run_line(13, "R1 R7 single sprite", -1);
    run_line(30, "R2 line outside sprite", -1);
  endtask

  task automatic t_flip();
    clear_all();
    wr(1, 100, 40, 9, 5, 2, 1, 1, 1);
    wr(2, 140, 40, 9, 6, 0, 0, 0, 1);
    wr(3, 180, 40, 9, 1, 3, 1, 0, 1);
    run_line(41, "R5 R6 flips upper row", -1);
    run_line(52, "R5 R6 flips lower row", -1);
  endtask

  task automatic t_large();
    clear_all();
    wr(7, 200, 100, 30, 4, 1, 0, 1, 2);
    wr(9, 240, 90, 60, 3, 2, 1, 0, 3);
    wr(11, 300, 95, 2, 7, 0, 0, 0, 1);
    run_line(110, "R2 R6 sizes 32 and 64 with right edge", -1);
  endtask

  task automatic t_overlap();
    clear_all();
    wr(3, 50, 20, 12, 1, 0, 0, 0, 1);
    wr(5, 54, 20, 40, 6, 3, 0, 0, 1);
    wr(6, 58, 250, 77, 2, 2, 0, 1, 1);
    run_line(5, "R8 R2 index wins over plane, wrap", -1);
  endtask

  task automatic t_spr_limit();
    clear_all();
    for (int i = 10; i < 50; i++) wr(i, (i - 10) * 6, 60, i, i & 7, i & 3, 0, 0, 0);
    run_line(62, "R3 sprite budget", -1);
  endtask

  task automatic t_tile_limit();
    clear_all();
    for (int i = 20; i < 25; i++) wr(i, (i - 20) * 50, 80, i * 8, i & 7, 3 - (i & 3), i & 1, 0, 3);
    run_line(90, "R4 slice budget", -1);
  endtask

  task automatic t_ignore();
    clear_all();
    wr(0, 20, 10, 4, 2, 1, 0, 0, 0);
    wr(1, 70, 60, 8, 3, 2, 0, 0, 0);
    run_line(13, "R11 restart ignored", 62);
  endtask

  initial begin
    t_reset();
    t_single();
    t_flip();
    t_large();
    t_overlap();
    t_spr_limit();
    t_tile_limit();
    t_ignore();
    summary();
    $finish;
  end
endmodule